// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that finishes one instruction in every clock cycle. It has two small internal word arrays, one for instructions and one for data. In each cycle it fetches the word at the program counter and splits it into fields. It then reads two operands from a 32-entry register file, runs them through an ALU and writes the result back. Multiplexers choose the second ALU operand, the destination register, the write-back source and the next program counter.

The instruction set is small. It has five register-to-register operations (add, sub, and, or, signed set-on-less-than), a word load, a word store, a branch taken when two registers are equal, and an absolute jump. Control is decoded in two stages. A main decoder turns the opcode into the datapath enables and a 2-bit operation class. A second decoder combines that class with the function field to produce the 4-bit ALU select.

Both memories are filled through a loader port, which writes only while reset is held. Every architectural effect appears on observation ports:
- the program counter and the fetched word,
- the ALU select,
- the register write-back event,
- the memory store event.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst_n` is low the program counter is 0 and every register reads 0. Loader writes (`ld_we`) are accepted only during reset. `ld_dmem`=1 targets the data array and 0 targets the instruction array, at word index `ld_addr`.
- R2: Opcode 0 uses the function field (bits 5:0) to pick the operation: 32 add, 34 sub, 36 and, 37 or. The result goes to register rd (bits 15:11). The operands are registers rs (bits 25:21) and rt (bits 20:16). The instruction raises `wb_en_o` and writes the register on the rising edge.
- R3: Function 42 with opcode 0 writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R4: Opcode 35 loads the data word at rs plus the sign-extended bits 15:0 into register rt. The word index is address bits MEM_AW+1:2.
- R5: Opcode 43 stores register rt at address rs plus the sign-extended bits 15:0. It raises `st_en_o` with that address and data, and it never raises `wb_en_o`.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise the next PC is PC+4.
- R7: Opcode 2 sets the next PC to bits 31:28 of the current PC, followed by bits 25:0 of the instruction, followed by two zero bits.
- R8: Register 0 always reads 0, and a write aimed at it is dropped.
- R9: Any opcode other than 0, 2, 4, 35 or 43 raises neither `wb_en_o` nor `st_en_o`, and the PC advances by 4.
- R10: `alu_sel_o` carries one of five codes:
  - 0010 (add) for opcodes 35 and 43,
  - 0110 (subtract) for opcode 4,
  - for opcode 0, chosen by the function field: 0010 add, 0110 sub, 0000 and, 0001 or, 0111 set-on-less-than.
- R11: All sequential writes (PC, register file, data store) happen on the rising clock edge. Register and memory reads are combinational within the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; the loader is enabled while it is low |
| ld_we | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 1 data array, 0 instruction array |
| ld_addr | input | MEM_AW | Loader word index |
| ld_data | input | 32 | Loader word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at `pc_o` |
| alu_sel_o | output | 4 | Decoded ALU select |
| wb_en_o | output | 1 | Register write-back this cycle |
| wb_reg_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Write-back value |
| st_en_o | output | 1 | Data store this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The assertions check several rules on every cycle:
- the PC is held at zero in reset,
- a store never coincides with a write-back,
- the PC after jumps and untaken branches,
- register 0 reading as zero,
- the ALU select for memory and branch instructions,
- the quiet behaviour of unknown opcodes.

Only the bench's scenarios can show that the values are right. It runs directed and random programs and compares every write-back value, store address and PC against an instruction-level model. This covers signed compares, store-then-load ordering, address wrap in both arrays, and jumps taken from a PC whose top bits are nonzero.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  typedef logic [31:0] word_t;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    SEL_AND = 4'b0000,
    SEL_OR  = 4'b0001,
    SEL_ADD = 4'b0010,
    SEL_SUB = 4'b0110,
    SEL_SLT = 4'b0111
  } alu_sel_e;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REG = 2'b10
  } op_class_e;

  typedef struct packed {
    logic      dst_is_rd;
    logic      branch;
    logic      mem_rd;
    logic      wb_from_mem;
    op_class_e op_class;
    logic      mem_wr;
    logic      b_is_imm;
    logic      reg_wr;
    logic      jump;
  } ctrl_t;

  function automatic word_t sext16(input logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  function automatic word_t branch_dest(input word_t pc_plus4, input logic [15:0] imm);
    return pc_plus4 + (sext16(imm) << 2);
  endfunction

  function automatic word_t jump_dest(input word_t pc, input logic [25:0] target);
    return {pc[31:28], target, 2'b00};
  endfunction

  function automatic word_t alu_eval(input logic [3:0] sel, input word_t a, input word_t b);
    word_t r;
    case (sel)
      SEL_AND: r = a & b;
      SEL_OR:  r = a | b;
      SEL_SUB: r = a - b;
      SEL_SLT: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: r = a + b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/core_main_dec.sv
module core_main_dec
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.op_class = CLS_MEM;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_wr    = 1'b1;
        ctrl.op_class  = CLS_REG;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.mem_rd      = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_wr      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_wr   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch   = 1'b1;
        ctrl.op_class = CLS_BRANCH;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/core_alu_dec.sv
module core_alu_dec
  import cpu_pkg::*;
(
  input  op_class_e  op_class,
  input  logic [5:0] funct,
  output logic [3:0] sel
);
  always_comb begin
    case (op_class)
      CLS_BRANCH: sel = SEL_SUB;
      CLS_REG: begin
        case (funct)
          FN_SUB:  sel = SEL_SUB;
          FN_AND:  sel = SEL_AND;
          FN_OR:   sel = SEL_OR;
          FN_SLT:  sel = SEL_SLT;
          default: sel = SEL_ADD;
        endcase
      end
      default: sel = SEL_ADD;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/core_alu.sv
module core_alu
  import cpu_pkg::*;
(
  input  logic [3:0] sel,
  input  word_t      a,
  input  word_t      b,
  output word_t      y,
  output logic       zero
);
  assign y    = alu_eval(sel, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
  import cpu_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREG   = 32,
  localparam int WORDS = 2 ** MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_o,
  output logic [31:0]       instr_o,
  output logic [3:0]        alu_sel_o,
  output logic              wb_en_o,
  output logic [4:0]        wb_reg_o,
  output logic [31:0]       wb_data_o,
  output logic              st_en_o,
  output logic [31:0]       st_addr_o,
  output logic [31:0]       st_data_o
);
  word_t imem [WORDS];
  word_t dmem [WORDS];
  word_t pc, pc_plus4, pc_next, instr;
  word_t rs_val, rt_val, alu_b, alu_y, mem_rdata, imm_ext;
  logic  alu_zero, take_branch;
  logic [3:0] alu_sel;
  ctrl_t ctrl;

  logic [5:0]  f_op, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic [15:0] f_imm;
  logic [25:0] f_tgt;

  assign instr = imem[pc[MEM_AW+1:2]];
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign f_tgt = instr[25:0];

  core_main_dec u_main (.opcode(f_op), .ctrl(ctrl));
  core_alu_dec  u_aludec (.op_class(ctrl.op_class), .funct(f_fn), .sel(alu_sel));

  core_regfile #(.NREG(NREG), .W(32)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(f_rs), .ra_b(f_rt), .rd_a(rs_val), .rd_b(rt_val),
    .we(ctrl.reg_wr), .wa(wb_reg_o), .wd(wb_data_o)
  );

  assign imm_ext = sext16(f_imm);
  assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;

  core_alu u_alu (.sel(alu_sel), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign mem_rdata   = ctrl.mem_rd ? dmem[alu_y[MEM_AW+1:2]] : '0;
  assign pc_plus4    = pc + 32'd4;
  assign take_branch = ctrl.branch & alu_zero;
  assign pc_next     = ctrl.jump   ? jump_dest(pc, f_tgt) :
                       take_branch ? branch_dest(pc_plus4, f_imm) : pc_plus4;

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n && ld_we && !ld_dmem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (ld_we && ld_dmem) dmem[ld_addr] <= ld_data;
    end else if (ctrl.mem_wr) begin
      dmem[alu_y[MEM_AW+1:2]] <= rt_val;
    end
  end

  assign pc_o      = pc;
  assign instr_o   = instr;
  assign alu_sel_o = alu_sel;
  assign wb_en_o   = ctrl.reg_wr;
  assign wb_reg_o  = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wb_data_o = ctrl.wb_from_mem ? mem_rdata : alu_y;
  assign st_en_o   = ctrl.mem_wr;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;
endmodule

// File: rtl/core_sva.sv
module core_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic [3:0]  alu_sel_o,
  input logic        wb_en_o,
  input logic        st_en_o,
  input logic [31:0] rs_val,
  input logic        alu_zero
);
  logic [5:0] op;
  logic       op_known;
  assign op       = instr_o[31:26];
  assign op_known = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) ||
                    (op == 6'd35) || (op == 6'd43);

  a_r1_pc_reset: assert property (@(posedge clk) !rst_n |=> (pc_o == 32'd0));

  a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    st_en_o |-> !wb_en_o);

  a_r6_untaken_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd4 && !alu_zero) |=> (pc_o == $past(pc_o) + 32'd4));

  a_r7_jump_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd2) |=> (pc_o == {$past(pc_o[31:28]), $past(instr_o[25:0]), 2'b00}));

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_o[25:21] == 5'd0) |-> (rs_val == 32'd0));

  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known |-> (!wb_en_o && !st_en_o));

  a_r9_unknown_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known |=> (pc_o == $past(pc_o) + 32'd4));

  a_r10_mem_add: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd35 || op == 6'd43) |-> (alu_sel_o == 4'b0010));

  a_r10_beq_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd4) |-> (alu_sel_o == 4'b0110));
endmodule

bind onecycle_cpu core_sva i_sva (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .instr_o(instr_o),
  .alu_sel_o(alu_sel_o), .wb_en_o(wb_en_o), .st_en_o(st_en_o),
  .rs_val(rs_val), .alu_zero(alu_zero)
);

// File: tb/test_onecycle_cpu.sv
`timescale 1ns/1ps
module test_onecycle_cpu;
  localparam int AW = 6;
  localparam int NW = 2 ** AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_we = 1'b0, ld_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, instr_o, wb_data_o, st_addr_o, st_data_o;
  logic [3:0]  alu_sel_o;
  logic        wb_en_o, st_en_o;
  logic [4:0]  wb_reg_o;

  always #2.5 clk = ~clk;

  onecycle_cpu #(.MEM_AW(AW)) i_onecycle_cpu (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
    .alu_sel_o(alu_sel_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
    .wb_data_o(wb_data_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o),
    .st_data_o(st_data_o)
  );

  int total = 0, fails = 0;
  logic [31:0] m_imem [NW];
  logic [31:0] m_dmem [NW];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  function automatic logic [3:0] want_sel(logic [31:0] ins);
    if (ins[31:26] == 6'd4) return 4'b0110;
    if (ins[31:26] != 6'd0) return 4'b0010;
    case (ins[5:0])
      6'd34: return 4'b0110;
      6'd36: return 4'b0000;
      6'd37: return 4'b0001;
      6'd42: return 4'b0111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [31:0] want_rop(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    if (fn == 6'd34) return a + ~b + 32'd1;
    if (fn == 6'd36) return a & b;
    if (fn == 6'd37) return a | b;
    if (fn == 6'd42) begin
      if (a[31] != b[31]) return {31'd0, a[31]};
      return {31'd0, (a < b)};
    end
    return a + b;
  endfunction

  task automatic load_and_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = AW'(i); ld_data = m_imem[i];
      @(negedge clk);
      ld_dmem = 1'b1; ld_data = m_dmem[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    rst_n = 1'b1;
  endtask

  task automatic run(int ncyc);
    for (int n = 0; n < ncyc; n++) begin
      logic [31:0] ins, a, b, se, npc, ea, res;
      logic [5:0] op;
      string tag;
      ins = m_imem[m_pc[AW+1:2]];
      op  = ins[31:26];
      a   = m_reg[ins[25:21]];
      b   = m_reg[ins[20:16]];
      se  = {{16{ins[15]}}, ins[15:0]};
      npc = m_pc + 32'd4;
      ea  = a + se;
      chk(pc_o == m_pc, "R11", "pc", pc_o, m_pc);
      chk(instr_o == ins, "R1", "fetched word", instr_o, ins);
      case (op)
        6'd0: begin
          tag = (ins[5:0] == 6'd42) ? "R3" : ((ins[25:21] == 5'd0) ? "R8" : "R2");
          res = want_rop(ins[5:0], a, b);
          chk(wb_en_o && !st_en_o, tag, "wb/st enables", {wb_en_o, st_en_o}, 32'd2);
          chk(wb_reg_o == ins[15:11], tag, "dest rd", wb_reg_o, ins[15:11]);
          chk(wb_data_o == res, tag, "result", wb_data_o, res);
          chk(alu_sel_o == want_sel(ins), "R10", "alu select", alu_sel_o, want_sel(ins));
          if (ins[15:11] != 5'd0) m_reg[ins[15:11]] = res;
        end
        6'd35: begin
          res = m_dmem[ea[AW+1:2]];
          chk(wb_en_o && !st_en_o, "R4", "wb/st enables", {wb_en_o, st_en_o}, 32'd2);
          chk(wb_reg_o == ins[20:16], "R4", "dest rt", wb_reg_o, ins[20:16]);
          chk(wb_data_o == res, "R4", "loaded word", wb_data_o, res);
          chk(alu_sel_o == 4'b0010, "R10", "alu select", alu_sel_o, 32'd2);
          if (ins[20:16] != 5'd0) m_reg[ins[20:16]] = res;
        end
        6'd43: begin
          chk(st_en_o && !wb_en_o, "R5", "st/wb enables", {st_en_o, wb_en_o}, 32'd2);
          chk(st_addr_o == ea, "R5", "store address", st_addr_o, ea);
          chk(st_data_o == b, "R5", "store data", st_data_o, b);
          m_dmem[ea[AW+1:2]] = b;
        end
        6'd4: begin
          chk(!wb_en_o && !st_en_o, "R6", "no side effects", {wb_en_o, st_en_o}, 32'd0);
          chk(alu_sel_o == 4'b0110, "R10", "alu select", alu_sel_o, 32'd6);
          if (a == b) npc = npc + {se[29:0], 2'b00};
        end
        6'd2: begin
          chk(!wb_en_o && !st_en_o, "R7", "no side effects", {wb_en_o, st_en_o}, 32'd0);
          npc = {m_pc[31:28], ins[25:0], 2'b00};
        end
        default: begin
          chk(!wb_en_o && !st_en_o, "R9", "unknown opcode quiet", {wb_en_o, st_en_o}, 32'd0);
        end
      endcase
      m_pc = npc;
      @(negedge clk);
    end
  endtask

  task automatic random_program();
    int fns[5] = '{32, 34, 36, 37, 42};
    int bad[6] = '{1, 3, 5, 8, 12, 63};
    for (int i = 0; i < NW; i++) begin
      int k;
      k = int'($urandom % 16);
      m_dmem[i] = ($urandom % 2) ? $urandom : ($urandom % 16) - 8;
      if (k < 6)       m_imem[i] = enc_r($urandom % 8, $urandom % 8, $urandom % 8, fns[$urandom % 5]);
      else if (k < 9)  m_imem[i] = enc_i(35, $urandom % 8, $urandom % 8, int'($urandom % 16) * 4 - 16);
      else if (k < 11) m_imem[i] = enc_i(43, $urandom % 8, $urandom % 8, int'($urandom % 16) * 4 - 16);
      else if (k < 13) m_imem[i] = enc_i(4, $urandom % 4, $urandom % 4, int'($urandom % 13) - 6);
      else if (k < 14) m_imem[i] = enc_j(int'($urandom));
      else             m_imem[i] = {6'(bad[$urandom % 6]), 26'($urandom)};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    for (int i = 0; i < NW; i++) begin
      m_imem[i] = {6'd63, 26'd0};
      m_dmem[i] = 32'h1000 + i;
    end
    m_dmem[0] = 32'd7;
    m_dmem[1] = 32'hFFFF_FFFD;
    m_imem[0]  = enc_i(35, 0, 1, 0);
    m_imem[1]  = enc_i(35, 0, 2, 4);
    m_imem[2]  = enc_r(1, 2, 3, 32);
    m_imem[3]  = enc_r(1, 2, 4, 34);
    m_imem[4]  = enc_r(1, 2, 5, 36);
    m_imem[5]  = enc_r(1, 2, 6, 37);
    m_imem[6]  = enc_r(2, 1, 7, 42);
    m_imem[7]  = enc_r(1, 2, 8, 42);
    m_imem[8]  = enc_r(1, 1, 0, 32);
    m_imem[9]  = enc_r(0, 1, 9, 32);
    m_imem[10] = enc_i(43, 1, 3, 8);
    m_imem[11] = enc_i(35, 1, 10, 8);
    m_imem[12] = enc_i(4, 1, 2, 5);
    m_imem[13] = enc_i(4, 3, 10, 2);
    m_imem[16] = {6'd8, 26'd0};
    m_imem[17] = enc_i(4, 0, 0, -20);
    m_imem[62] = enc_j(20);
    m_imem[20] = enc_i(43, 0, 1, -4);
    m_imem[21] = enc_i(35, 0, 11, -4);
    m_imem[22] = enc_r(0, 11, 12, 32);
    m_imem[23] = enc_j(23);
    load_and_reset();
    run(40);
    for (int p = 0; p < 5; p++) begin
      random_program();
      load_and_reset();
      run(300);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule